// File: doc/BRIEF.md
# Radio Frame Buffer Burst Engine

This block moves whole frames over SPI between a local byte RAM and the frame buffer of an external radio transceiver. A receive request opens a burst with the frame-read command and clocks in the length byte. It checks that length against a minimum and a maximum bound. If the length is in range, it clocks in that many payload bytes and writes them to local RAM, then clocks in one more byte, which is the link-quality value. It reports the length, the quality byte and a valid flag. If the length is out of range, it closes the burst at once and reports zeros.

A transmit request opens a burst with the frame-write command. It sends the length byte held at RAM address 0, with bit 7 forced to zero, and then the payload from address 1 upward. When the radio appends the frame checksum itself, the auto-checksum option drops the last two payload bytes. The length byte is sent unchanged and still counts those two bytes.

The SPI link uses mode 0, MSB first. The SCK half period is a parameter. Slave select stays low from the command byte to the last byte of the burst.

Top module: `fbuf_burst`

## Requirements
- R1: A receive burst drives ss_n low, sends command 0x20, and then sends 0x00 on MOSI for every byte it clocks in.
- R2: For a length L with LEN_MIN <= L <= LEN_MAX (defaults 3 and 127), the L bytes that follow the length byte go to RAM addresses 0 to L-1. The byte after them sets rx_lqi. rx_len becomes L and rx_ok becomes 1. The burst is L+3 bytes long.
- R3: For a length below LEN_MIN or above LEN_MAX, rx_len, rx_lqi and rx_ok become 0 and no RAM write occurs. ss_n is released after the length byte, so the burst is 2 bytes long.
- R4: With auto_fcs low, a transmit burst sends command 0x60, then RAM[0] with bit 7 cleared as the length byte, then RAM[1] to RAM[L], where L = RAM[0][6:0].
- R5: With auto_fcs high when tx_req is taken, only L-2 payload bytes are sent (none if L <= 2). The length byte is still L.
- R6: ss_n stays low without a break for the whole burst. done is a one-cycle pulse in the cycle ss_n returns high. busy is high whenever ss_n is low.
- R7: The SPI link runs in mode 0. SCK is low whenever ss_n is high. Data goes MSB first: MOSI changes after the falling edge and MISO is sampled on the rising edge. Each byte takes 16*SCK_HALF clock cycles.
- R8: A rx_req or tx_req that arrives while a burst is running is ignored. No second burst follows.
- R9: When rx_req and tx_req are asserted in the same idle cycle, the receive burst is started.
- R10: After reset, ss_n=1, sck=0, done=0, busy=0, rx_ok=0, rx_len=0 and rx_lqi=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_req | input | 1 | Start a frame upload (taken when idle) |
| tx_req | input | 1 | Start a frame download (taken when idle) |
| auto_fcs | input | 1 | Radio generates the checksum; skip last two payload bytes |
| ram_addr | output | AW | Local RAM address |
| ram_we | output | 1 | Local RAM write strobe |
| ram_wdata | output | 8 | Local RAM write data |
| ram_rdata | input | 8 | Local RAM read data (combinational read of ram_addr) |
| ss_n | output | 1 | SPI slave select, active low |
| sck | output | 1 | SPI clock |
| mosi | output | 1 | SPI data to radio |
| miso | input | 1 | SPI data from radio |
| busy | output | 1 | Burst in progress |
| done | output | 1 | One-cycle pulse when the burst ends |
| rx_len | output | 8 | Received frame length, 0 on length error |
| rx_lqi | output | 8 | Received link-quality byte, 0 on length error |
| rx_ok | output | 1 | Last receive had a valid length |

## Verification
Each byte takes 16*SCK_HALF cycles. The receive results are registered when the last byte finishes. The next cycle is spent in the release state, and ss_n rises together with done one edge later. The bench therefore waits for done on the falling clock edge and only then reads rx_len, rx_lqi, rx_ok, the RAM model and the byte log of the slave model. Once done has been seen, every result is already final.

The bench checks the byte counts of each burst against the length arithmetic of R2, R3 and R5. After a request made during a running burst, it watches the lines for a further idle window to confirm that no second burst starts.

// File: rtl/fbuf_pkg.sv
package fbuf_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_CMD,
    S_LEN,
    S_PAY,
    S_LQI,
    S_FIN
  } fb_state_e;

  localparam logic [7:0] OP_FRAME_UPLOAD   = 8'h20;
  localparam logic [7:0] OP_FRAME_DOWNLOAD = 8'h60;

  // Payload bytes actually shifted out for a given length byte.
  function automatic logic [7:0] tx_pay_count(input logic [6:0] len, input logic fcs_by_radio);
    if (!fcs_by_radio)      return {1'b0, len};
    else if (len > 7'd2)    return {1'b0, len} - 8'd2;
    else                    return 8'd0;
  endfunction

  function automatic logic len_in_range(input logic [7:0] len, input int lo, input int hi);
    return (int'(len) >= lo) && (int'(len) <= hi);
  endfunction

endpackage

// File: rtl/fbuf_spi_byte.sv
module fbuf_spi_byte #(
  parameter int SCK_HALF = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go,
  input  logic [7:0] din,
  input  logic       miso,
  output logic       sck,
  output logic       mosi,
  output logic [7:0] dout,
  output logic       fin
);

  localparam int CW = (SCK_HALF > 1) ? $clog2(SCK_HALF) : 1;
  localparam logic [CW-1:0] DIV_LAST = CW'(SCK_HALF - 1);

  logic [CW-1:0] div_q;
  logic [2:0]    bit_q;
  logic [7:0]    tx_sh, rx_sh;
  logic          run_q, sck_q, fin_q;
  logic          tick;

  assign tick = (div_q == DIV_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      bit_q <= '0;
      tx_sh <= '0;
      rx_sh <= '0;
      run_q <= 1'b0;
      sck_q <= 1'b0;
      fin_q <= 1'b0;
    end else begin
      fin_q <= 1'b0;
      if (go && !run_q) begin
        run_q <= 1'b1;
        tx_sh <= din;
        div_q <= '0;
        bit_q <= '0;
        sck_q <= 1'b0;
      end else if (run_q) begin
        if (tick) begin
          div_q <= '0;
          if (!sck_q) begin
            sck_q <= 1'b1;
            rx_sh <= {rx_sh[6:0], miso};
          end else begin
            sck_q <= 1'b0;
            tx_sh <= {tx_sh[6:0], 1'b0};
            bit_q <= bit_q + 3'd1;
            if (bit_q == 3'd7) begin
              run_q <= 1'b0;
              fin_q <= 1'b1;
            end
          end
        end else begin
          div_q <= div_q + 1'b1;
        end
      end
    end
  end

  assign sck  = sck_q;
  assign mosi = tx_sh[7];
  assign dout = rx_sh;
  assign fin  = fin_q;

endmodule

// File: rtl/fbuf_lenchk.sv
module fbuf_lenchk
  import fbuf_pkg::*;
#(
  parameter int LEN_MIN = 3,
  parameter int LEN_MAX = 127
) (
  input  logic [7:0] len,
  output logic       ok
);

  assign ok = len_in_range(len, LEN_MIN, LEN_MAX);

endmodule

// File: rtl/fbuf_burst.sv
module fbuf_burst
  import fbuf_pkg::*;
#(
  parameter int SCK_HALF = 2,
  parameter int LEN_MIN  = 3,
  parameter int LEN_MAX  = 127,
  parameter int AW       = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_req,
  input  logic          tx_req,
  input  logic          auto_fcs,
  output logic [AW-1:0] ram_addr,
  output logic          ram_we,
  output logic [7:0]    ram_wdata,
  input  logic [7:0]    ram_rdata,
  output logic          ss_n,
  output logic          sck,
  output logic          mosi,
  input  logic          miso,
  output logic          busy,
  output logic          done,
  output logic [7:0]    rx_len,
  output logic [7:0]    rx_lqi,
  output logic          rx_ok
);

  fb_state_e     state_q;
  logic          is_tx_q, fcs_q, ss_q, go_q, done_q;
  logic [7:0]    byte_q, len_q, rem_q;
  logic [AW-1:0] addr_q, wptr_q;
  logic          sh_fin, len_ok;
  logic [7:0]    sh_dout;

  // Named events for the checker
  logic          bad_len_ev;
  assign bad_len_ev = (state_q == S_LEN) && sh_fin && !is_tx_q && !len_ok;

  fbuf_spi_byte #(.SCK_HALF(SCK_HALF)) u_shift (
    .clk  (clk),
    .rst_n(rst_n),
    .go   (go_q),
    .din  (byte_q),
    .miso (miso),
    .sck  (sck),
    .mosi (mosi),
    .dout (sh_dout),
    .fin  (sh_fin)
  );

  fbuf_lenchk #(.LEN_MIN(LEN_MIN), .LEN_MAX(LEN_MAX)) u_len (
    .len(sh_dout),
    .ok (len_ok)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= S_IDLE;
      is_tx_q   <= 1'b0;
      fcs_q     <= 1'b0;
      ss_q      <= 1'b1;
      go_q      <= 1'b0;
      done_q    <= 1'b0;
      byte_q    <= '0;
      len_q     <= '0;
      rem_q     <= '0;
      addr_q    <= '0;
      wptr_q    <= '0;
      ram_we    <= 1'b0;
      ram_wdata <= '0;
      rx_len    <= '0;
      rx_lqi    <= '0;
      rx_ok     <= 1'b0;
    end else begin
      go_q   <= 1'b0;
      done_q <= 1'b0;
      ram_we <= 1'b0;
      unique case (state_q)
        S_IDLE: begin
          if (rx_req) begin
            is_tx_q <= 1'b0;
            ss_q    <= 1'b0;
            byte_q  <= OP_FRAME_UPLOAD;
            go_q    <= 1'b1;
            state_q <= S_CMD;
          end else if (tx_req) begin
            is_tx_q <= 1'b1;
            fcs_q   <= auto_fcs;
            ss_q    <= 1'b0;
            byte_q  <= OP_FRAME_DOWNLOAD;
            go_q    <= 1'b1;
            addr_q  <= '0;
            state_q <= S_CMD;
          end
        end
        S_CMD: if (sh_fin) begin
          go_q    <= 1'b1;
          state_q <= S_LEN;
          if (is_tx_q) begin
            byte_q <= {1'b0, ram_rdata[6:0]};
            rem_q  <= tx_pay_count(ram_rdata[6:0], fcs_q);
            addr_q <= addr_q + 1'b1;
          end else begin
            byte_q <= 8'h00;
          end
        end
        S_LEN: if (sh_fin) begin
          if (is_tx_q) begin
            if (rem_q == 8'd0) begin
              state_q <= S_FIN;
            end else begin
              byte_q  <= ram_rdata;
              addr_q  <= addr_q + 1'b1;
              rem_q   <= rem_q - 8'd1;
              go_q    <= 1'b1;
              state_q <= S_PAY;
            end
          end else if (len_ok) begin
            len_q   <= sh_dout;
            rem_q   <= sh_dout - 8'd1;
            wptr_q  <= '0;
            byte_q  <= 8'h00;
            go_q    <= 1'b1;
            state_q <= S_PAY;
          end else begin
            rx_len  <= '0;
            rx_lqi  <= '0;
            rx_ok   <= 1'b0;
            state_q <= S_FIN;
          end
        end
        S_PAY: if (sh_fin) begin
          if (is_tx_q) begin
            if (rem_q == 8'd0) begin
              state_q <= S_FIN;
            end else begin
              byte_q <= ram_rdata;
              addr_q <= addr_q + 1'b1;
              rem_q  <= rem_q - 8'd1;
              go_q   <= 1'b1;
            end
          end else begin
            ram_we    <= 1'b1;
            ram_wdata <= sh_dout;
            addr_q    <= wptr_q;
            wptr_q    <= wptr_q + 1'b1;
            byte_q    <= 8'h00;
            go_q      <= 1'b1;
            if (rem_q == 8'd0) state_q <= S_LQI;
            else               rem_q   <= rem_q - 8'd1;
          end
        end
        S_LQI: if (sh_fin) begin
          rx_lqi  <= sh_dout;
          rx_len  <= len_q;
          rx_ok   <= 1'b1;
          state_q <= S_FIN;
        end
        S_FIN: begin
          ss_q    <= 1'b1;
          done_q  <= 1'b1;
          state_q <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign ram_addr = addr_q;
  assign ss_n     = ss_q;
  assign done     = done_q;
  assign busy     = (state_q != S_IDLE);

endmodule

// File: rtl/fbuf_burst_chk.sv
module fbuf_burst_chk #(
  parameter int LEN_MIN = 3,
  parameter int LEN_MAX = 127
) (
  input logic       clk,
  input logic       rst_n,
  input logic       ss_n,
  input logic       sck,
  input logic       done,
  input logic       busy,
  input logic       ram_we,
  input logic       rx_ok,
  input logic [7:0] rx_len,
  input logic       bad_len_ev
);

  // R6
  ss_release_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ss_n) |-> done);

  // R6
  done_at_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $rose(ss_n));

  // R6
  busy_while_selected_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ss_n |-> busy);

  // R7
  sck_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ss_n |-> !sck);

  // R3
  bad_len_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bad_len_ev |-> ##2 $rose(ss_n));

  // R3
  bad_len_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bad_len_ev |=> !ram_we);

  // R2
  rx_ok_len_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ok |-> (int'(rx_len) >= LEN_MIN && int'(rx_len) <= LEN_MAX));

  // R1
  write_inside_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> !ss_n);

endmodule

bind fbuf_burst fbuf_burst_chk #(.LEN_MIN(LEN_MIN), .LEN_MAX(LEN_MAX)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ss_n      (ss_n),
  .sck       (sck),
  .done      (done),
  .busy      (busy),
  .ram_we    (ram_we),
  .rx_ok     (rx_ok),
  .rx_len    (rx_len),
  .bad_len_ev(bad_len_ev)
);

// File: tb/tb_fbuf_burst.sv
`timescale 1ns/1ps
module tb_fbuf_burst;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_req = 1'b0, tx_req = 1'b0, auto_fcs = 1'b0;
  logic [7:0] ram_addr, ram_wdata, ram_rdata;
  logic       ram_we, ss_n, sck, mosi, miso, busy, done, rx_ok;
  logic [7:0] rx_len, rx_lqi;

  always #2.5 clk = ~clk;

  fbuf_burst dut (
    .clk(clk), .rst_n(rst_n), .rx_req(rx_req), .tx_req(tx_req), .auto_fcs(auto_fcs),
    .ram_addr(ram_addr), .ram_we(ram_we), .ram_wdata(ram_wdata), .ram_rdata(ram_rdata),
    .ss_n(ss_n), .sck(sck), .mosi(mosi), .miso(miso), .busy(busy), .done(done),
    .rx_len(rx_len), .rx_lqi(rx_lqi), .rx_ok(rx_ok)
  );

  // Local RAM model
  logic [7:0] mem [0:255];
  always @(posedge clk) if (ram_we) mem[ram_addr] <= ram_wdata;
  assign ram_rdata = mem[ram_addr];

  // Radio slave model (mode 0, MSB first)
  logic [7:0] sl_out [0:255];
  logic [7:0] sl_in  [0:255];
  logic [7:0] sl_sh;
  int sl_nin = 0, sl_bit = 0;
  always @(posedge sck or negedge ss_n) begin
    if (sck == 1'b0) begin
      sl_nin = 0;
      sl_bit = 0;
    end else if (!ss_n) begin
      sl_sh = {sl_sh[6:0], mosi};
      sl_bit = sl_bit + 1;
      if (sl_bit == 8) begin
        sl_in[sl_nin & 255] = sl_sh;
        sl_nin = sl_nin + 1;
        sl_bit = 0;
      end
    end
  end
  assign miso = ss_n ? 1'b0 : sl_out[sl_nin & 255][7 - sl_bit];

  // Line monitors
  int ss_falls = 0, sck_bad = 0, done_bad = 0;
  logic done_d = 1'b0;
  always @(negedge ss_n) ss_falls++;
  always @(negedge clk) begin
    if (rst_n && ss_n && sck) sck_bad++;
    if (rst_n && done && (done_d || !ss_n)) done_bad++;
    if (rst_n && !ss_n && !busy) done_bad++;
    done_d <= done;
  end

  int checks = 0, errors = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=1 expected=0");
    summary();
  end

  task automatic wait_done();
    do @(negedge clk); while (!done);
  endtask

  task automatic pulse(input bit r, input bit t);
    @(negedge clk);
    rx_req = r;
    tx_req = t;
    @(negedge clk);
    rx_req = 1'b0;
    tx_req = 1'b0;
  endtask

  // Upload scenario: R1, R2, R3
  task automatic run_rx(input int L, input int lqi);
    bit exp_ok;
    int exp_bytes, bad_mosi, bad_mem;
    exp_ok = (L >= 3) && (L <= 127);
    for (int i = 0; i < 256; i++) begin
      mem[i] = 8'hEE;
      sl_out[i] = 8'(i * 13 + L + 5);
    end
    sl_out[0] = 8'h00;
    sl_out[1] = 8'(L);
    if (exp_ok) sl_out[2 + L] = 8'(lqi);
    pulse(1'b1, 1'b0);
    wait_done();
    exp_bytes = exp_ok ? L + 3 : 2;
    chk(sl_in[0] == 8'h20, "R1", "upload command byte", sl_in[0], 32);
    bad_mosi = 0;
    for (int i = 1; i < exp_bytes; i++) if (sl_in[i] != 8'h00) bad_mosi++;
    chk(bad_mosi == 0, "R1", "non-zero filler bytes", bad_mosi, 0);
    if (exp_ok) begin
      chk(sl_nin == exp_bytes, "R2", "upload burst bytes", sl_nin, exp_bytes);
      chk(rx_len == 8'(L) && rx_ok, "R2", "rx_len with ok", rx_len, L);
      chk(rx_lqi == 8'(lqi), "R2", "quality byte", rx_lqi, lqi);
      bad_mem = 0;
      for (int i = 0; i < L; i++) if (mem[i] != sl_out[2 + i]) bad_mem++;
      if (mem[L] != 8'hEE) bad_mem++;
      chk(bad_mem == 0, "R2", "RAM payload mismatches", bad_mem, 0);
    end else begin
      chk(sl_nin == 2, "R3", "bad-length burst bytes", sl_nin, 2);
      chk(rx_len == 0 && rx_lqi == 0 && !rx_ok, "R3", "bad-length report (len)", rx_len, 0);
      chk(mem[0] == 8'hEE, "R3", "RAM[0] untouched", mem[0], 238);
    end
  endtask

  // Download scenario: R4, R5
  task automatic run_tx(input int raw_len, input bit fcs);
    int L, n, bad;
    string rq;
    rq = fcs ? "R5" : "R4";
    L = raw_len & 127;
    n = fcs ? ((L > 2) ? L - 2 : 0) : L;
    for (int i = 0; i < 256; i++) mem[i] = 8'(i * 29 + 3);
    mem[0] = 8'(raw_len);
    for (int i = 0; i < 256; i++) sl_out[i] = 8'hA5;
    @(negedge clk);
    auto_fcs = fcs;
    pulse(1'b0, 1'b1);
    auto_fcs = 1'b0;
    wait_done();
    chk(sl_in[0] == 8'h60, rq, "download command byte", sl_in[0], 96);
    chk(sl_in[1] == 8'(L), rq, "length byte", sl_in[1], L);
    chk(sl_nin == n + 2, rq, "download burst bytes", sl_nin, n + 2);
    bad = 0;
    for (int i = 0; i < n; i++) if (sl_in[2 + i] != mem[1 + i]) bad++;
    chk(bad == 0, rq, "payload mismatches", bad, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    // R10: reset state
    chk(ss_n && !sck && !done && !busy, "R10", "idle lines", {ss_n, sck, done, busy}, 8);
    chk(!rx_ok && rx_len == 0 && rx_lqi == 0, "R10", "result regs", rx_len, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    run_rx(10, 8'h5C);
    run_rx(3, 8'h11);
    run_rx(127, 8'hF0);
    run_rx(2, 8'h00);
    run_rx(128, 8'h00);
    run_rx(0, 8'h00);

    run_tx(5, 1'b0);
    run_tx(8'h85, 1'b0);
    run_tx(6, 1'b1);
    run_tx(2, 1'b1);
    run_tx(127, 1'b1);

    // R9: both requests together -> upload
    for (int i = 0; i < 256; i++) sl_out[i] = 8'h00;
    sl_out[1] = 8'd4;
    pulse(1'b1, 1'b1);
    wait_done();
    chk(sl_in[0] == 8'h20, "R9", "command when both requested", sl_in[0], 32);

    // R8: request during a running burst is ignored
    begin
      int falls0;
      sl_out[1] = 8'd6;
      falls0 = ss_falls;
      pulse(1'b1, 1'b0);
      repeat (40) @(negedge clk);
      pulse(1'b0, 1'b1);
      pulse(1'b1, 1'b0);
      wait_done();
      repeat (100) @(negedge clk);
      chk(ss_falls - falls0 == 1, "R8", "bursts started", ss_falls - falls0, 1);
      chk(rx_len == 8'd6 && rx_ok, "R8", "upload result intact", rx_len, 6);
    end

    chk(sck_bad == 0, "R7", "sck high while deselected", sck_bad, 0);
    chk(done_bad == 0, "R6", "done/select/busy violations", done_bad, 0);
    summary();
  end

endmodule